// File: doc/BRIEF.md
# Zero Run-Length Codec for 64-bit Words

The block holds two independent paths. The encoder path accepts a stream of 16-bit activation values. Each stream ends on a value marked as last. The encoder folds runs of zeros into short counts and packs the result into 64-bit code words that suit an external memory port. The decoder path takes those code words and rebuilds the original value stream, including its end marker.

A code word holds three slots. A slot is a 5-bit zero count followed by a 16-bit value. The top bit of the word flags the final word of a stream. A 2-bit side signal travels with each word and gives how many slots are in use, so a stream that ends part-way through a word needs no sentinel values. Every port uses a valid/ready handshake. Either side can stall the codec at any time without losing or repeating any value.

Top module: `zrl_codec`

## Requirements
- R1: Slot k of a code word (k = 0, 1, 2) holds its zero count in bits [21k+4:21k] and its value in bits [21k+20:21k+5]. Bit 63 is the end-of-stream flag.
- R2: The encoder counts consecutive zero inputs in a run of up to 31. The first non-zero input ends the run and is stored as the slot value with that count. The count then restarts at 0.
- R3: When a run already holds 31 zeros and the next input is also zero, that zero is stored as the slot value with count 31. A new run starts after it.
- R4: The input marked last always closes a slot, with value 0 if it is zero, and emits the word with bit 63 set. Unused slots of that word are all-zero. The slot count output is 1 to 3 and equals the number of slots used. Every word without bit 63 carries 3 slots.
- R5: While the encoder word output is valid and not accepted, the word and the slot count stay unchanged and valid stays high.
- R6: The decoder expands the first n slots of each word, where n is the slot count given with it (1 to 3). Each slot becomes its count of zeros followed by its value. The decoded stream equals the encoder input exactly, and the last marker is raised only on the final value of a word with bit 63 set.
- R7: While the decoder value output is valid and not accepted, the value and the last marker stay unchanged and valid stays high.
- R8: The decoder accepts a new word only when no value of the previous word is pending. Its word-ready is low whenever its value output is valid.
- R9: After reset, neither output is valid, and both the encoder input and the decoder word input are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Input value valid |
| enc_ready_o | output | 1 | Encoder can take a value |
| enc_data_i | input | 16 | Input value |
| enc_last_i | input | 1 | Value ends the stream |
| enc_word_o | output | 64 | Encoded word |
| enc_npairs_o | output | 2 | Slots used in enc_word_o |
| enc_word_valid_o | output | 1 | Encoded word valid |
| enc_word_ready_i | input | 1 | Consumer takes encoded word |
| dec_word_i | input | 64 | Word to decode |
| dec_npairs_i | input | 2 | Slots used in dec_word_i |
| dec_word_valid_i | input | 1 | Word to decode valid |
| dec_word_ready_o | output | 1 | Decoder can take a word |
| dec_data_o | output | 16 | Decoded value |
| dec_last_o | output | 1 | Decoded value ends the stream |
| dec_valid_o | output | 1 | Decoded value valid |
| dec_ready_i | input | 1 | Consumer takes decoded value |

## Verification
The hardest cases to reach from the ports involve a saturated run. One is a run at 31 whose next input is a zero. Another is a stream whose final input is a zero inside an unfinished run. A third is a stream that stops after one or two slots of a word. Random values rarely produce these. Directed streams therefore build each of them, including runs far longer than 31. Zero-heavy random streams then cover the rest while random stalls are applied on all three handshakes, with the encoder output looped into the decoder.

// File: rtl/zrl_pkg.sv
package zrl_pkg;
  localparam int unsigned VAL_W  = 16;
  localparam int unsigned RUN_W  = 5;
  localparam int unsigned PAIRS  = 3;
  localparam int unsigned WORD_W = 64;
endpackage

// File: rtl/zrl_enc.sv
module zrl_enc #(
  parameter int unsigned VAL_W  = zrl_pkg::VAL_W,
  parameter int unsigned RUN_W  = zrl_pkg::RUN_W,
  parameter int unsigned PAIRS  = zrl_pkg::PAIRS,
  parameter int unsigned WORD_W = zrl_pkg::WORD_W,
  localparam int unsigned PAIR_W = RUN_W + VAL_W,
  localparam int unsigned BODY_W = PAIRS * PAIR_W,
  localparam int unsigned CNT_W  = $clog2(PAIRS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [VAL_W-1:0]  in_data_i,
  input  logic              in_last_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  npairs_o,
  output logic              word_valid_o,
  input  logic              word_ready_i
);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [RUN_W-1:0]  run_q;
  logic [CNT_W-1:0]  idx_q;
  logic [BODY_W-1:0] acc_q, acc_n;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  np_q;
  logic              ov_q;
  logic              fire, close, done;

  assign in_ready_o   = !ov_q || word_ready_i;
  assign fire         = in_valid_i && in_ready_o;
  // a slot closes on non-zero data, a full run, or the end of stream
  assign close        = (in_data_i != '0) || (run_q == RUN_MAX) || in_last_i;
  assign done         = close && ((idx_q == CNT_W'(PAIRS - 1)) || in_last_i);
  assign word_o       = word_q;
  assign npairs_o     = np_q;
  assign word_valid_o = ov_q;

  always_comb begin
    acc_n = acc_q;
    for (int k = 0; k < PAIRS; k++) begin
      if (idx_q == CNT_W'(k)) acc_n[k*PAIR_W +: PAIR_W] = {in_data_i, run_q};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      idx_q  <= '0;
      acc_q  <= '0;
      word_q <= '0;
      np_q   <= '0;
      ov_q   <= 1'b0;
    end else begin
      if (ov_q && word_ready_i) ov_q <= 1'b0;
      if (fire) begin
        if (!close) begin
          run_q <= run_q + 1'b1;
        end else begin
          run_q <= '0;
          if (done) begin
            word_q <= WORD_W'({in_last_i, acc_n});
            np_q   <= idx_q + 1'b1;
            ov_q   <= 1'b1;
            acc_q  <= '0;
            idx_q  <= '0;
          end else begin
            acc_q <= acc_n;
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/zrl_dec.sv
module zrl_dec #(
  parameter int unsigned VAL_W  = zrl_pkg::VAL_W,
  parameter int unsigned RUN_W  = zrl_pkg::RUN_W,
  parameter int unsigned PAIRS  = zrl_pkg::PAIRS,
  parameter int unsigned WORD_W = zrl_pkg::WORD_W,
  localparam int unsigned PAIR_W = RUN_W + VAL_W,
  localparam int unsigned CNT_W  = $clog2(PAIRS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  npairs_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic [VAL_W-1:0]  out_data_o,
  output logic              out_last_o,
  output logic              out_valid_o,
  input  logic              out_ready_i
);
  logic              busy_q;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  np_q, idx_q;
  logic [RUN_W-1:0]  zc_q;
  logic [RUN_W-1:0]  cur_run;
  logic [VAL_W-1:0]  cur_lvl;
  logic              at_lvl, last_pair, take;

  always_comb begin
    cur_run = '0;
    cur_lvl = '0;
    for (int k = 0; k < PAIRS; k++) begin
      if (idx_q == CNT_W'(k)) begin
        cur_run = word_q[k*PAIR_W +: RUN_W];
        cur_lvl = word_q[k*PAIR_W + RUN_W +: VAL_W];
      end
    end
  end

  assign at_lvl       = (zc_q == cur_run);
  assign last_pair    = (idx_q == np_q - 1'b1);
  assign take         = busy_q && out_ready_i;
  assign word_ready_o = !busy_q;
  assign out_valid_o  = busy_q;
  assign out_data_o   = at_lvl ? cur_lvl : '0;
  assign out_last_o   = at_lvl && last_pair && word_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      word_q <= '0;
      np_q   <= '0;
      idx_q  <= '0;
      zc_q   <= '0;
    end else if (!busy_q) begin
      if (word_valid_i) begin
        busy_q <= 1'b1;
        word_q <= word_i;
        np_q   <= npairs_i;
        idx_q  <= '0;
        zc_q   <= '0;
      end
    end else if (take) begin
      if (!at_lvl) begin
        zc_q <= zc_q + 1'b1;
      end else begin
        zc_q <= '0;
        if (last_pair) busy_q <= 1'b0;
        else           idx_q  <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/zrl_codec.sv
module zrl_codec #(
  parameter int unsigned VAL_W  = zrl_pkg::VAL_W,
  parameter int unsigned RUN_W  = zrl_pkg::RUN_W,
  parameter int unsigned PAIRS  = zrl_pkg::PAIRS,
  parameter int unsigned WORD_W = zrl_pkg::WORD_W,
  localparam int unsigned CNT_W = $clog2(PAIRS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_valid_i,
  output logic              enc_ready_o,
  input  logic [VAL_W-1:0]  enc_data_i,
  input  logic              enc_last_i,
  output logic [WORD_W-1:0] enc_word_o,
  output logic [CNT_W-1:0]  enc_npairs_o,
  output logic              enc_word_valid_o,
  input  logic              enc_word_ready_i,
  input  logic [WORD_W-1:0] dec_word_i,
  input  logic [CNT_W-1:0]  dec_npairs_i,
  input  logic              dec_word_valid_i,
  output logic              dec_word_ready_o,
  output logic [VAL_W-1:0]  dec_data_o,
  output logic              dec_last_o,
  output logic              dec_valid_o,
  input  logic              dec_ready_i
);
  zrl_enc #(.VAL_W(VAL_W), .RUN_W(RUN_W), .PAIRS(PAIRS), .WORD_W(WORD_W)) u_enc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (enc_valid_i),
    .in_ready_o  (enc_ready_o),
    .in_data_i   (enc_data_i),
    .in_last_i   (enc_last_i),
    .word_o      (enc_word_o),
    .npairs_o    (enc_npairs_o),
    .word_valid_o(enc_word_valid_o),
    .word_ready_i(enc_word_ready_i)
  );

  zrl_dec #(.VAL_W(VAL_W), .RUN_W(RUN_W), .PAIRS(PAIRS), .WORD_W(WORD_W)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_i      (dec_word_i),
    .npairs_i    (dec_npairs_i),
    .word_valid_i(dec_word_valid_i),
    .word_ready_o(dec_word_ready_o),
    .out_data_o  (dec_data_o),
    .out_last_o  (dec_last_o),
    .out_valid_o (dec_valid_o),
    .out_ready_i (dec_ready_i)
  );
endmodule

// File: rtl/zrl_codec_chk.sv
module zrl_codec_chk #(
  parameter int unsigned VAL_W  = zrl_pkg::VAL_W,
  parameter int unsigned RUN_W  = zrl_pkg::RUN_W,
  parameter int unsigned PAIRS  = zrl_pkg::PAIRS,
  parameter int unsigned WORD_W = zrl_pkg::WORD_W,
  localparam int unsigned PAIR_W = RUN_W + VAL_W,
  localparam int unsigned CNT_W  = $clog2(PAIRS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] enc_word_o,
  input logic [CNT_W-1:0]  enc_npairs_o,
  input logic              enc_word_valid_o,
  input logic              enc_word_ready_i,
  input logic              dec_word_ready_o,
  input logic [VAL_W-1:0]  dec_data_o,
  input logic              dec_last_o,
  input logic              dec_valid_o,
  input logic              dec_ready_i
);
  p_enc_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_word_valid_o && !enc_word_ready_i |=>
      enc_word_valid_o && $stable(enc_word_o) && $stable(enc_npairs_o));

  p_dec_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && !dec_ready_i |=>
      dec_valid_o && $stable(dec_data_o) && $stable(dec_last_o));

  p_npairs_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_word_valid_o |-> enc_npairs_o != '0 && enc_npairs_o <= CNT_W'(PAIRS));

  p_full_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_word_valid_o && !enc_word_o[WORD_W-1] |-> enc_npairs_o == CNT_W'(PAIRS));

  p_pad_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_word_valid_o && enc_npairs_o == CNT_W'(1) |->
      enc_word_o[PAIRS*PAIR_W-1:PAIR_W] == '0);

  p_dec_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> !dec_word_ready_o);
endmodule

bind zrl_codec zrl_codec_chk #(
  .VAL_W(VAL_W), .RUN_W(RUN_W), .PAIRS(PAIRS), .WORD_W(WORD_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .enc_word_o      (enc_word_o),
  .enc_npairs_o    (enc_npairs_o),
  .enc_word_valid_o(enc_word_valid_o),
  .enc_word_ready_i(enc_word_ready_i),
  .dec_word_ready_o(dec_word_ready_o),
  .dec_data_o      (dec_data_o),
  .dec_last_o      (dec_last_o),
  .dec_valid_o     (dec_valid_o),
  .dec_ready_i     (dec_ready_i)
);

// File: tb/zrl_codec_bench.sv
module zrl_codec_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enc_valid_i = 1'b0;
  logic        enc_ready_o;
  logic [15:0] enc_data_i = '0;
  logic        enc_last_i = 1'b0;
  logic [63:0] enc_word_o;
  logic [1:0]  enc_npairs_o;
  logic        enc_word_valid_o;
  logic        enc_word_ready_i;
  logic        dec_word_valid_i;
  logic        dec_word_ready_o;
  logic [15:0] dec_data_o;
  logic        dec_last_o;
  logic        dec_valid_o;
  logic        dec_ready_i = 1'b0;
  logic        gate = 1'b0;

  always #4 clk_i = ~clk_i;

  assign dec_word_valid_i = enc_word_valid_o && gate;
  assign enc_word_ready_i = dec_word_ready_o && gate;

  zrl_codec u_zrl_codec (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .enc_valid_i     (enc_valid_i),
    .enc_ready_o     (enc_ready_o),
    .enc_data_i      (enc_data_i),
    .enc_last_i      (enc_last_i),
    .enc_word_o      (enc_word_o),
    .enc_npairs_o    (enc_npairs_o),
    .enc_word_valid_o(enc_word_valid_o),
    .enc_word_ready_i(enc_word_ready_i),
    .dec_word_i      (enc_word_o),
    .dec_npairs_i    (enc_npairs_o),
    .dec_word_valid_i(dec_word_valid_i),
    .dec_word_ready_o(dec_word_ready_o),
    .dec_data_o      (dec_data_o),
    .dec_last_o      (dec_last_o),
    .dec_valid_o     (dec_valid_o),
    .dec_ready_i     (dec_ready_i)
  );

  int unsigned total = 0;
  int unsigned bad = 0;
  int unsigned cycles = 0;
  bit          timeout = 1'b0;
  logic [15:0] stim [0:255];
  int          len;
  logic [65:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [65:0] act, input logic [65:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference packing: slot k count at 21k, value at 21k+5, end flag at 63
  task automatic model();
    logic [63:0] w = '0;
    int run = 0;
    int idx = 0;
    exp_q.delete();
    for (int i = 0; i < len; i++) begin
      bit lst = (i == len - 1);
      if (stim[i] == 16'd0 && run < 31 && !lst) begin
        run++;
      end else begin
        w[21*idx +: 5]    = run[4:0];
        w[21*idx + 5 +: 16] = stim[i];
        idx++;
        run = 0;
        if (idx == 3 || lst) begin
          w[63] = lst;
          exp_q.push_back({idx[1:0], w});
          w = '0;
          idx = 0;
        end
      end
    end
  endtask

  task automatic run_stream(input string tag);
    int ip = 0, wi = 0, vo = 0;
    bit done = 1'b0;
    bit hold_e = 1'b0, hold_d = 1'b0;
    logic [65:0] save_e = '0;
    logic [16:0] save_d = '0;
    model();
    while (!done) begin
      @(negedge clk_i);
      if (hold_e)
        chk(enc_word_valid_o && {enc_npairs_o, enc_word_o} == save_e, "R5",
            "held word", {enc_npairs_o, enc_word_o}, save_e);
      if (hold_d)
        chk(dec_valid_o && {dec_last_o, dec_data_o} == save_d, "R7",
            "held value", 66'({dec_last_o, dec_data_o}), 66'(save_d));
      enc_valid_i = (ip < len) && ($urandom % 4 != 0);
      enc_data_i  = (ip < len) ? stim[ip] : 16'd0;
      enc_last_i  = (ip == len - 1);
      gate        = ($urandom % 3 != 0);
      dec_ready_i = ($urandom % 4 != 0);
      #1;
      if (dec_valid_o)
        chk(!dec_word_ready_o, "R8", "ready while busy", 66'(dec_word_ready_o), 66'(0));
      hold_e = enc_word_valid_o && !enc_word_ready_i;
      save_e = {enc_npairs_o, enc_word_o};
      hold_d = dec_valid_o && !dec_ready_i;
      save_d = {dec_last_o, dec_data_o};
      if (enc_valid_i && enc_ready_o) ip++;
      if (enc_word_valid_o && enc_word_ready_i) begin
        if (wi < exp_q.size()) begin
          logic [65:0] e = exp_q[wi];
          if (e[63] != enc_word_o[63] || e[65:64] != enc_npairs_o)
            chk(1'b0, "R4", "end flag/slot count", {enc_npairs_o, enc_word_o}, e);
          else
            chk({enc_npairs_o, enc_word_o} == e, tag, "word", {enc_npairs_o, enc_word_o}, e);
        end else begin
          chk(1'b0, tag, "extra word", {enc_npairs_o, enc_word_o}, 66'(0));
        end
        wi++;
      end
      if (dec_valid_o && dec_ready_i) begin
        logic [16:0] ev = (vo < len) ? {vo == len - 1, stim[vo]} : 17'h1ffff;
        chk({dec_last_o, dec_data_o} == ev, "R6", "decoded value",
            66'({dec_last_o, dec_data_o}), 66'(ev));
        vo++;
        if (dec_last_o || vo > len) done = 1'b1;
      end
      cycles++;
      if (cycles > 190000) begin
        timeout = 1'b1;
        done = 1'b1;
      end
    end
    chk(wi == exp_q.size(), "R4", "word count", 66'(wi), 66'(exp_q.size()));
    chk(vo == len, "R6", "value count", 66'(vo), 66'(len));
    enc_valid_i = 1'b0;
  endtask

  task automatic fill_rand(input int n, input int zero_pct);
    len = n;
    for (int i = 0; i < n; i++)
      stim[i] = ($urandom % 100 < zero_pct) ? 16'd0 : 16'(($urandom % 65535) + 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk_i);
    chk(!enc_word_valid_o && !dec_valid_o && enc_ready_o && dec_word_ready_o,
        "R9", "state in reset", 66'({enc_word_valid_o, dec_valid_o, enc_ready_o, dec_word_ready_o}),
        66'(4'b0011));
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!enc_word_valid_o && !dec_valid_o && enc_ready_o && dec_word_ready_o,
        "R9", "state after reset", 66'({enc_word_valid_o, dec_valid_o, enc_ready_o, dec_word_ready_o}),
        66'(4'b0011));

    // R3: 32 zeros then 7 -> slot (31,0) then (0,7)
    len = 33; for (int i = 0; i < 33; i++) stim[i] = 16'd0; stim[32] = 16'd7;
    if (!timeout) run_stream("R3");
    // R3: long zero run crossing several saturations
    len = 71; for (int i = 0; i < 71; i++) stim[i] = 16'd0; stim[70] = 16'd5;
    if (!timeout) run_stream("R3");
    // R4: single zero
    len = 1; stim[0] = 16'd0;
    if (!timeout) run_stream("R4");
    // R4: single non-zero
    len = 1; stim[0] = 16'hbeef;
    if (!timeout) run_stream("R4");
    // R4: trailing zeros after a value
    len = 5; stim[0] = 16'd9; for (int i = 1; i < 5; i++) stim[i] = 16'd0;
    if (!timeout) run_stream("R4");
    // R4: exactly three slots, full final word
    len = 3; stim[0] = 16'd1; stim[1] = 16'd2; stim[2] = 16'd3;
    if (!timeout) run_stream("R4");
    // R2: mixed short runs, two words
    len = 9;
    stim[0] = 0; stim[1] = 0; stim[2] = 5; stim[3] = 0; stim[4] = 1;
    stim[5] = 0; stim[6] = 0; stim[7] = 0; stim[8] = 3;
    if (!timeout) run_stream("R2");
    // R1: non-zero only, exercises every field position
    len = 6; for (int i = 0; i < 6; i++) stim[i] = 16'(16'h1111 * (i + 1));
    if (!timeout) run_stream("R1");

    for (int s = 0; s < 40; s++) begin
      fill_rand(1 + int'($urandom % 120), (s % 4 == 0) ? 97 : 70);
      if (!timeout) run_stream("R2");
    end

    if (timeout) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule